// File: doc/BRIEF.md
# Two-Level DMA Pipe Interrupt Aggregator

This block gathers event pulses from a set of DMA pipes and from the DMA controller itself, and turns them into a single level-high interrupt line for one execution environment. Each pipe keeps six sticky cause bits. A cause bit is set by an event pulse whether or not it is enabled, and software clears it by writing ones to a separate clear register. An enable register chooses which causes count toward that pipe's pending state. The controller has its own sticky cause bank with four causes. It also has its own enable and clear registers.

The pending state of every pipe, plus the controller pending state, forms a source bitmap. A mask register with the same layout as the bitmap picks which sources may drive the output. Software reaches all registers through a plain single-cycle register port: a write takes effect at the clock edge where `reg_we` is high, and reads are combinational from the addressed register.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every cause status, every enable, the mask and `irq_out` are zero.
- R2: A pulse on a pipe event input sets the matching status bit at the next clock edge, whether or not that bit is enabled. The pipe cause bits are: 0 processed descriptor, 1 timer, 2 wake, 3 out of descriptors, 4 error, 5 transfer end. Pipe p's cause c is input `pipe_evt[p*6+c]`.
- R3: Writing a pipe or controller clear register clears exactly the status bits written as 1 and leaves the others unchanged. Clear registers read as zero.
- R4: If an event pulse and a clear of the same bit occur in the same cycle, the bit stays set.
- R5: Source bit p (p < NUM_PIPES) is 1 when pipe p has any status bit that is also enabled. Source bits from NUM_PIPES to 30 always read 0.
- R6: Source bit 31 is 1 when the controller has any enabled status bit set. The controller cause bits are: 1 bus response error, 2 error, 3 empty, 4 timer. Input `ctrl_evt[i]` sets bit i+1. Bit 0 and bits above 4 are never set.
- R7: `irq_out` is high while any source bit that is also set in the mask is 1, and it stays high until a register write removes that condition.
- R8: Writing 0 to the mask makes `irq_out` low from the next cycle on and changes no status bit.
- R9: Enable registers and the mask store only their defined bits: bits 5:0 for a pipe enable, bits 4:1 for the controller enable, and bits NUM_PIPES-1:0 plus bit 31 for the mask. All other bits read back as 0.
- R10: The word address map is: 0x00 source (read-only, writes ignored), 0x01 mask, 0x02 controller status, 0x03 controller clear, 0x04 controller enable. For pipe p, status is at 0x08+4p, clear at 0x09+4p and enable at 0x0A+4p. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_evt | input | NUM_PIPES*6 | Event pulses, six per pipe |
| ctrl_evt | input | 4 | Controller event pulses for causes 1 to 4 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | 1 | Level-high aggregated interrupt |

## Verification
On every cycle, the assertions check four things. A posted event is captured. Event-over-clear priority holds. A clear write removes only the bits it names. A zero mask write silences the output, and the line never drops without a register write. Other behaviour shows only in the bench scenarios:

- which bit lands where in the source bitmap;
- address decoding and read-as-zero fields;
- the per-pipe independence of status and enable.

The bench's cycle model compares this against the design over a long random phase.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Cause bank widths and defined-bit masks
    localparam int PIPE_CAUSE_W = 6;
    localparam int CTRL_CAUSE_W = 5;
    localparam logic [PIPE_CAUSE_W-1:0] PIPE_VALID = 6'h3F;
    localparam logic [CTRL_CAUSE_W-1:0] CTRL_VALID = 5'b11110;

    // Word address map
    localparam int ADDR_SRC     = 0;
    localparam int ADDR_MASK    = 1;
    localparam int ADDR_CSTAT   = 2;
    localparam int ADDR_CCLR    = 3;
    localparam int ADDR_CEN     = 4;
    localparam int PIPE_BASE    = 8;
    localparam int PIPE_STRIDE  = 4;
    localparam int OFF_STAT     = 0;
    localparam int OFF_CLR      = 1;
    localparam int OFF_EN       = 2;

    localparam int SRC_CTRL_BIT = 31;

    typedef enum logic [2:0] {
        RD_NONE,
        RD_SRC,
        RD_MASK,
        RD_CSTAT,
        RD_CEN,
        RD_PSTAT,
        RD_PEN
    } rd_kind_e;

endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int             W     = 6,
    parameter logic [W-1:0]   VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_we,
    input  logic         en_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         pending
);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] enable;
    } bank_t;

    bank_t st_d, st_q;
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_we ? wdata : '0;
        set_bits = evt & VALID;
        // clear first, then set: an event in the same cycle wins
        st_d.status = (st_q.status & ~clr_bits) | set_bits;
        if (en_we) begin
            st_d.enable = wdata & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status  = st_q.status;
    assign enable  = st_q.enable;
    assign pending = |(st_q.status & st_q.enable);

    // R2: a posted event is visible in status after the edge
    assert_evt_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & VALID)) |=> ((status & $past(evt & VALID)) == $past(evt & VALID)));

    // R4: event and clear on the same bit, the bit stays set
    assert_evt_beats_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && |(evt & wdata & VALID))
        |=> ((status & $past(evt & wdata & VALID)) == $past(evt & wdata & VALID)));

    // R3: a clear with no event removes the written bits
    assert_clr_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !(|evt)) |=> ((status & $past(wdata)) == '0));

    // R9: undefined bits never hold a one
    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | enable) & ~VALID) == '0);

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int ADDR_W    = 8,
    parameter int PIDX_W    = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic                 mask_we,
    output logic                 ctrl_clr_we,
    output logic                 ctrl_en_we,
    output logic [NUM_PIPES-1:0] pipe_clr_we,
    output logic [NUM_PIPES-1:0] pipe_en_we,
    output rd_kind_e             rd_kind,
    output logic [PIDX_W-1:0]    rd_pipe
);

    localparam int PIPE_END = PIPE_BASE + PIPE_STRIDE * NUM_PIPES;

    logic [31:0] a;
    logic [31:0] rel;
    logic [31:0] idx;
    logic [31:0] off;

    always_comb begin
        a           = 32'(addr);
        rel         = a - 32'(PIPE_BASE);
        idx         = rel / 32'(PIPE_STRIDE);
        off         = rel % 32'(PIPE_STRIDE);
        mask_we     = 1'b0;
        ctrl_clr_we = 1'b0;
        ctrl_en_we  = 1'b0;
        pipe_clr_we = '0;
        pipe_en_we  = '0;
        rd_kind     = RD_NONE;
        rd_pipe     = '0;
        if (a == 32'(ADDR_SRC)) begin
            rd_kind = RD_SRC;
        end else if (a == 32'(ADDR_MASK)) begin
            rd_kind = RD_MASK;
            mask_we = we;
        end else if (a == 32'(ADDR_CSTAT)) begin
            rd_kind = RD_CSTAT;
        end else if (a == 32'(ADDR_CCLR)) begin
            ctrl_clr_we = we;
        end else if (a == 32'(ADDR_CEN)) begin
            rd_kind    = RD_CEN;
            ctrl_en_we = we;
        end else if (a >= 32'(PIPE_BASE) && a < 32'(PIPE_END)) begin
            rd_pipe = PIDX_W'(idx);
            for (int p = 0; p < NUM_PIPES; p++) begin
                if (idx == 32'(p)) begin
                    if (off == 32'(OFF_CLR)) pipe_clr_we[p] = we;
                    if (off == 32'(OFF_EN))  pipe_en_we[p]  = we;
                end
            end
            if (off == 32'(OFF_STAT)) rd_kind = RD_PSTAT;
            else if (off == 32'(OFF_EN)) rd_kind = RD_PEN;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PIPES*PIPE_CAUSE_W-1:0] pipe_evt,
    input  logic [3:0]                        ctrl_evt,
    input  logic                              reg_we,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    output logic                              irq_out
);

    localparam int PIDX_W = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1;
    localparam logic [31:0] SRC_VALID =
        (32'd1 << SRC_CTRL_BIT) | ((32'd1 << NUM_PIPES) - 32'd1);

    typedef struct packed {
        logic [31:0] mask;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                    mask_we, ctrl_clr_we, ctrl_en_we;
    logic [NUM_PIPES-1:0]    pipe_clr_we, pipe_en_we;
    rd_kind_e                rd_kind;
    logic [PIDX_W-1:0]       rd_pipe;

    logic [PIPE_CAUSE_W-1:0] pipe_stat [NUM_PIPES];
    logic [PIPE_CAUSE_W-1:0] pipe_en   [NUM_PIPES];
    logic [NUM_PIPES-1:0]    pipe_pend;
    logic [CTRL_CAUSE_W-1:0] ctrl_stat, ctrl_en;
    logic                    ctrl_pend;
    logic [31:0]             src;

    irq_addr_decode #(
        .NUM_PIPES (NUM_PIPES),
        .ADDR_W    (ADDR_W),
        .PIDX_W    (PIDX_W)
    ) u_decode (
        .addr        (reg_addr),
        .we          (reg_we),
        .mask_we     (mask_we),
        .ctrl_clr_we (ctrl_clr_we),
        .ctrl_en_we  (ctrl_en_we),
        .pipe_clr_we (pipe_clr_we),
        .pipe_en_we  (pipe_en_we),
        .rd_kind     (rd_kind),
        .rd_pipe     (rd_pipe)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        irq_cause_bank #(
            .W     (PIPE_CAUSE_W),
            .VALID (PIPE_VALID)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (pipe_evt[p*PIPE_CAUSE_W +: PIPE_CAUSE_W]),
            .clr_we  (pipe_clr_we[p]),
            .en_we   (pipe_en_we[p]),
            .wdata   (reg_wdata[PIPE_CAUSE_W-1:0]),
            .status  (pipe_stat[p]),
            .enable  (pipe_en[p]),
            .pending (pipe_pend[p])
        );
    end

    irq_cause_bank #(
        .W     (CTRL_CAUSE_W),
        .VALID (CTRL_VALID)
    ) u_ctrl_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({ctrl_evt, 1'b0}),
        .clr_we  (ctrl_clr_we),
        .en_we   (ctrl_en_we),
        .wdata   (reg_wdata[CTRL_CAUSE_W-1:0]),
        .status  (ctrl_stat),
        .enable  (ctrl_en),
        .pending (ctrl_pend)
    );

    // Source bitmap: first level of aggregation
    always_comb begin
        src = '0;
        for (int p = 0; p < NUM_PIPES; p++) begin
            src[p] = pipe_pend[p];
        end
        src[SRC_CTRL_BIT] = ctrl_pend;
    end

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = reg_wdata & SRC_VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Second level: environment mask gates the output
    assign irq_out = |(src & st_q.mask);

    always_comb begin
        case (rd_kind)
            RD_SRC:   reg_rdata = src;
            RD_MASK:  reg_rdata = st_q.mask;
            RD_CSTAT: reg_rdata = 32'(ctrl_stat);
            RD_CEN:   reg_rdata = 32'(ctrl_en);
            RD_PSTAT: reg_rdata = 32'(pipe_stat[rd_pipe]);
            RD_PEN:   reg_rdata = 32'(pipe_en[rd_pipe]);
            default:  reg_rdata = '0;
        endcase
    end

    // R8: a zero mask write silences the line from the next cycle
    assert_mask_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(ADDR_MASK) && reg_wdata == '0) |=> !irq_out);

    // R7: the line is level; without a register write it cannot drop
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !reg_we) |=> irq_out);

endmodule

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;

    localparam int NP = 4;
    localparam int AW = 8;
    localparam logic [31:0] SRC_OK = 32'h8000_000F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*6-1:0]   pipe_evt = '0;
    logic [3:0]        ctrl_evt = '0;
    logic              reg_we = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_ps [NP];
    logic [31:0] m_pe [NP];
    logic [31:0] m_cs, m_ce, m_mask;

    always #2 clk = ~clk;

    irq_aggregator #(.NUM_PIPES(NP), .ADDR_W(AW)) u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .pipe_evt(pipe_evt), .ctrl_evt(ctrl_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [31:0] m_src();
        logic [31:0] s = '0;
        for (int p = 0; p < NP; p++) if ((m_ps[p] & m_pe[p]) != 0) s[p] = 1'b1;
        if ((m_cs & m_ce) != 0) s[31] = 1'b1;
        return s;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return m_src();
        if (a == 1) return m_mask;
        if (a == 2) return m_cs;
        if (a == 4) return m_ce;
        if (a >= 8 && a < 8 + 4*NP) begin
            if ((a - 8) % 4 == 0) return m_ps[(a - 8) / 4];
            if ((a - 8) % 4 == 2) return m_pe[(a - 8) / 4];
        end
        return 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin m_ps[p] = 0; m_pe[p] = 0; end
            m_cs = 0; m_ce = 0; m_mask = 0;
        end else begin
            int a;
            a = int'(reg_addr);
            if (reg_we) begin
                if (a == 1) m_mask = reg_wdata & SRC_OK;
                else if (a == 3) m_cs = m_cs & ~reg_wdata;
                else if (a == 4) m_ce = reg_wdata & 32'h1E;
                else if (a >= 8 && a < 8 + 4*NP) begin
                    if ((a - 8) % 4 == 1) m_ps[(a-8)/4] = m_ps[(a-8)/4] & ~reg_wdata;
                    if ((a - 8) % 4 == 2) m_pe[(a-8)/4] = reg_wdata & 32'h3F;
                end
            end
            for (int p = 0; p < NP; p++) m_ps[p] = m_ps[p] | 32'(pipe_evt[p*6 +: 6]);
            m_cs = m_cs | 32'({ctrl_evt, 1'b0});
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the reference (R7 output, R10 read path)
    always @(posedge clk) begin
        #1;
        chk("R10 model readback", reg_rdata, m_read(int'(reg_addr)));
        chk("R7 model irq", 32'(irq_out), ((m_src() & m_mask) != 0) ? 32'h1 : 32'h0);
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic look(input int a, input logic [31:0] exp_rd, input logic exp_irq,
                        input string tag);
        @(negedge clk);
        reg_addr = AW'(a);
        @(posedge clk);
        #1;
        chk(tag, reg_rdata, exp_rd);
        chk(tag, 32'(irq_out), 32'(exp_irq));
    endtask

    task automatic pulse_pipe(input int p, input logic [5:0] bits);
        @(negedge clk);
        pipe_evt[p*6 +: 6] = bits;
        @(negedge clk);
        pipe_evt = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        look(0, 32'h0, 1'b0, "R1 source after reset");
        look(1, 32'h0, 1'b0, "R1 mask after reset");
        look(8, 32'h0, 1'b0, "R1 pipe0 status after reset");
        look(10, 32'h0, 1'b0, "R1 pipe0 enable after reset");
        // R2 event captured while disabled
        pulse_pipe(1, 6'b100001);
        look(12, 32'h21, 1'b0, "R2 pipe1 status");
        look(0, 32'h0, 1'b0, "R5 source with nothing enabled");
        // R9 enable keeps defined bits only
        wr(14, 32'hFF);
        look(14, 32'h3F, 1'b0, "R9 pipe1 enable readback");
        look(0, 32'h2, 1'b0, "R5 source pipe1 pending, masked");
        wr(1, 32'hFFFF_FFFF);
        look(1, 32'h8000_000F, 1'b1, "R9 mask defined bits");
        repeat (3) @(negedge clk);
        look(0, 32'h2, 1'b1, "R7 irq stays high");
        // R8 mask zero silences next cycle, status kept
        wr(1, 32'h0);
        chk("R8 irq low after mask zero", 32'(irq_out), 32'h0);
        look(12, 32'h21, 1'b0, "R8 status unchanged");
        wr(1, 32'h2);
        look(0, 32'h2, 1'b1, "R7 irq with pipe1 unmasked");
        // R3 write-one-to-clear
        wr(13, 32'h01);
        look(12, 32'h20, 1'b1, "R3 partial clear");
        look(13, 32'h0, 1'b1, "R3 clear register reads zero");
        wr(13, 32'h20);
        look(12, 32'h0, 1'b0, "R3 full clear drops irq");
        // R4 event beats clear
        @(negedge clk);
        pipe_evt[6 + 4] = 1'b1;
        reg_we = 1'b1; reg_addr = AW'(13); reg_wdata = 32'h10;
        @(negedge clk);
        pipe_evt = '0; reg_we = 1'b0;
        look(12, 32'h10, 1'b1, "R4 event wins over clear");
        // R6 controller causes
        @(negedge clk);
        ctrl_evt = 4'b0101;
        @(negedge clk);
        ctrl_evt = 4'b0000;
        look(2, 32'h0A, 1'b1, "R6 controller status bits 1 and 3");
        look(0, 32'h2, 1'b1, "R6 source bit31 clear while disabled");
        wr(4, 32'hFF);
        look(4, 32'h1E, 1'b1, "R9 controller enable readback");
        look(0, 32'h8000_0002, 1'b1, "R6 source bit31 set");
        wr(1, 32'h8000_0000);
        look(0, 32'h8000_0002, 1'b1, "R6 irq from controller only");
        wr(3, 32'h0A);
        look(0, 32'h2, 1'b0, "R6 controller cleared drops irq");
        // R10 map corners
        look(7, 32'h0, 1'b0, "R10 unmapped 0x07");
        look(8'hF0, 32'h0, 1'b0, "R10 unmapped 0xF0");
        wr(0, 32'hFFFF);
        look(0, 32'h2, 1'b0, "R10 source write ignored");
        // R5 other pipes independent
        pulse_pipe(3, 6'b001000);
        wr(22, 32'h08);
        look(0, 32'h0000_000A, 1'b0, "R5 pipe3 source bit");
        // random phase against the reference
        for (int i = 0; i < 3000; i++) begin
            int r;
            @(negedge clk);
            pipe_evt = NP*6'($urandom & $urandom & $urandom);
            ctrl_evt = 4'($urandom & $urandom & $urandom);
            reg_we = ($urandom % 3) == 0;
            reg_wdata = $urandom;
            r = $urandom % 8;
            case (r)
                0: reg_addr = AW'(1);
                1: reg_addr = AW'(3);
                2: reg_addr = AW'(4);
                3: reg_addr = AW'(9 + 4 * ($urandom % NP));
                4: reg_addr = AW'(10 + 4 * ($urandom % NP));
                5: reg_addr = AW'(0);
                6: reg_addr = AW'($urandom);
                default: reg_addr = AW'(8 + 4 * ($urandom % NP));
            endcase
        end
        @(negedge clk);
        pipe_evt = '0; ctrl_evt = '0; reg_we = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule